// File: doc/BRIEF.md
# Hashed Frame-Indexed Page Table Walker

This block turns a virtual page number, tagged with a process identifier, into a physical frame number. The translation table is indexed by physical frame: there is exactly one entry per frame, so its depth follows the physical memory size and does not grow with virtual space or with the number of processes. Each entry carries a valid bit, a dirty bit, the owning process identifier, the virtual page number it maps, and a chain pointer to the next entry in the same collision chain.

A lookup folds the key with XOR down to the index width. The result is the first slot to probe. In each cycle the walker reads one entry and compares its tag with the key. On a match, the probed index is the frame number. On a mismatch it moves to the entry named by the chain pointer. The walk ends with a fault when the chain pointer holds the null value, which is all ones, or when the number of probes reaches the table depth. The step limit keeps a corrupted circular chain from hanging the walker.

Software loads entries through a single-cycle write port. Lookups use a valid/ready request and a one-cycle response pulse. Only one walk is active at a time.

Top module: `frame_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. Every entry is cleared to valid=0, dirty=0 and chain pointer all ones, so any lookup then faults after one probe.
- R2: The first probed index is the XOR of all IDX_W-bit groups of the key, zero-padded at the top. The key is {pid, vpn} with vpn in the low bits when HASH_PID=1, and vpn alone when HASH_PID=0. With the defaults this is the XOR of the five vpn nibbles and the two pid nibbles.
- R3: A probed entry hits only when its valid bit is 1 and both its vpn and pid equal the key. The response then has `rsp_fault`=0, `rsp_frame` equal to the probed index, and `rsp_dirty` equal to the entry's dirty bit. A matching vpn with a different pid does not hit.
- R4: On a mismatch the walker probes the entry named by the chain pointer on the next cycle. A lookup that takes N probes gives its `rsp_valid` pulse N cycles after the clock edge that accepted it.
- R5: An entry whose valid bit is 0 never hits, even when its tag matches. The walk continues through its chain pointer.
- R6: A mismatching entry whose chain pointer is all ones (the null value) ends the walk with `rsp_fault`=1.
- R7: If DEPTH = 2^IDX_W probes all mismatch, the walk ends with `rsp_fault`=1 after exactly DEPTH probes, even when the chain is circular.
- R8: `req_ready` is low from the accepting edge until the response. Requests presented while it is low are not taken and produce no response. `rsp_valid` lasts one cycle, and `req_ready` is high while it is asserted.
- R9: A write with `wr_en`=1 replaces the entry at `wr_idx` at the clock edge. A lookup accepted after that edge sees the new contents, including a cleared valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_pid | input | PID_W | Process identifier of the request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | 1: no mapping found (page fault) |
| rsp_frame | output | IDX_W | Frame number on a hit, zero on a fault |
| rsp_dirty | output | 1 | Dirty bit of the hit entry |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | IDX_W | Frame index of the entry written |
| wr_valid | input | 1 | Valid bit written |
| wr_dirty | input | 1 | Dirty bit written |
| wr_vpn | input | VPN_W | Virtual page tag written |
| wr_pid | input | PID_W | Process tag written |
| wr_next | input | IDX_W | Chain pointer written (all ones = end) |

## Verification
A wrong chain pointer, a stale key register or a step counter that is off by one changes how many probes a walk takes. The bench predicts the response cycle of every lookup exactly, so any of these faults shows on the very lookup that uses the bad state, as a late, early or missing strobe. A wrong compare or a wrong hash shows at the same response, as a wrong fault flag or a wrong frame. A walker that accepts a request while busy shows as an unexpected extra response within DEPTH cycles.

// File: rtl/fwalk_pkg.sv
package fwalk_pkg;

   typedef enum logic [0:0] {
      WALK_IDLE = 1'b0,
      WALK_BUSY = 1'b1
   } walk_state_e;

   function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
      return (a + b - 1) / b;
   endfunction

endpackage

// File: rtl/fwalk_hash.sv
module fwalk_hash #(
   parameter int unsigned VPN_W    = 20,
   parameter int unsigned PID_W    = 8,
   parameter int unsigned IDX_W    = 4,
   parameter bit          HASH_PID = 1'b1
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [PID_W-1:0] pid,
   output logic [IDX_W-1:0] idx
);
   import fwalk_pkg::*;

   localparam int unsigned KEY_W = HASH_PID ? (VPN_W + PID_W) : VPN_W;
   localparam int unsigned NCH   = ceil_div(KEY_W, IDX_W);
   localparam int unsigned PAD_W = NCH * IDX_W;

   logic [KEY_W-1:0] key;
   logic [PAD_W-1:0] padded;
   logic [IDX_W-1:0] acc [NCH+1];

   // Key composition: process tag folded in or left out
   generate
      if (HASH_PID) begin : g_key_with_pid
         assign key = {pid, vpn};
      end else begin : g_key_vpn_only
         logic unused_pid;
         assign key        = vpn;
         assign unused_pid = ^pid;
      end
   endgenerate

   assign padded = PAD_W'(key);
   assign acc[0] = '0;

   // XOR-fold, one index-wide slice per stage
   generate
      for (genvar c = 0; c < NCH; c++) begin : g_fold
         assign acc[c+1] = acc[c] ^ padded[c*IDX_W +: IDX_W];
      end
   endgenerate

   assign idx = acc[NCH];

endmodule

// File: rtl/fwalk_table.sv
module fwalk_table #(
   parameter int unsigned VPN_W = 20,
   parameter int unsigned PID_W = 8,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_valid,
   input  logic             wr_dirty,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PID_W-1:0] wr_pid,
   input  logic [IDX_W-1:0] wr_next,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic             rd_dirty,
   output logic [VPN_W-1:0] rd_vpn,
   output logic [PID_W-1:0] rd_pid,
   output logic [IDX_W-1:0] rd_next
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   typedef struct packed {
      logic             valid;
      logic             dirty;
      logic [PID_W-1:0] pid;
      logic [VPN_W-1:0] vpn;
      logic [IDX_W-1:0] next;
   } slot_t;

   slot_t slots [DEPTH];
   slot_t rd_slot;

   // One register row per frame
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_row
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slots[g] <= '{valid: 1'b0, dirty: 1'b0, pid: '0, vpn: '0, next: '1};
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
               slots[g] <= '{valid: wr_valid, dirty: wr_dirty, pid: wr_pid,
                             vpn: wr_vpn, next: wr_next};
            end
         end
      end
   endgenerate

   assign rd_slot  = slots[rd_idx];
   assign rd_valid = rd_slot.valid;
   assign rd_dirty = rd_slot.dirty;
   assign rd_vpn   = rd_slot.vpn;
   assign rd_pid   = rd_slot.pid;
   assign rd_next  = rd_slot.next;

endmodule

// File: rtl/fwalk_ctrl.sv
module fwalk_ctrl #(
   parameter int unsigned VPN_W = 20,
   parameter int unsigned PID_W = 8,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VPN_W-1:0] req_vpn,
   input  logic [PID_W-1:0] req_pid,
   input  logic [IDX_W-1:0] hash_idx,
   output logic             req_ready,
   output logic [IDX_W-1:0] probe_idx,
   input  logic             rd_valid,
   input  logic             rd_dirty,
   input  logic [VPN_W-1:0] rd_vpn,
   input  logic [PID_W-1:0] rd_pid,
   input  logic [IDX_W-1:0] rd_next,
   output logic             rsp_valid,
   output logic             rsp_fault,
   output logic [IDX_W-1:0] rsp_frame,
   output logic             rsp_dirty
);
   import fwalk_pkg::*;

   localparam logic [IDX_W-1:0] NULL_IDX  = '1;
   localparam logic [IDX_W-1:0] LAST_STEP = '1;

   walk_state_e      state;
   logic [VPN_W-1:0] key_vpn;
   logic [PID_W-1:0] key_pid;
   logic [IDX_W-1:0] cur_idx;
   logic [IDX_W-1:0] steps;

   logic tag_hit;
   logic chain_end;
   logic out_of_steps;

   assign tag_hit      = rd_valid && (rd_vpn == key_vpn) && (rd_pid == key_pid);
   assign chain_end    = (rd_next == NULL_IDX);
   assign out_of_steps = (steps == LAST_STEP);
   assign probe_idx    = cur_idx;
   assign req_ready    = (state == WALK_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= WALK_IDLE;
         key_vpn   <= '0;
         key_pid   <= '0;
         cur_idx   <= '0;
         steps     <= '0;
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_frame <= '0;
         rsp_dirty <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            WALK_IDLE: begin
               if (req_valid) begin
                  key_vpn <= req_vpn;
                  key_pid <= req_pid;
                  cur_idx <= hash_idx;
                  steps   <= '0;
                  state   <= WALK_BUSY;
               end
            end
            WALK_BUSY: begin
               if (tag_hit) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b0;
                  rsp_frame <= cur_idx;
                  rsp_dirty <= rd_dirty;
                  state     <= WALK_IDLE;
               end else if (chain_end || out_of_steps) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b1;
                  rsp_frame <= '0;
                  rsp_dirty <= 1'b0;
                  state     <= WALK_IDLE;
               end else begin
                  cur_idx <= rd_next;
                  steps   <= steps + 1'b1;
               end
            end
            default: state <= WALK_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/frame_walker.sv
module frame_walker #(
   parameter int unsigned VPN_W    = 20,
   parameter int unsigned PID_W    = 8,
   parameter int unsigned IDX_W    = 4,
   parameter bit          HASH_PID = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VPN_W-1:0] req_vpn,
   input  logic [PID_W-1:0] req_pid,
   output logic             rsp_valid,
   output logic             rsp_fault,
   output logic [IDX_W-1:0] rsp_frame,
   output logic             rsp_dirty,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_valid,
   input  logic             wr_dirty,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PID_W-1:0] wr_pid,
   input  logic [IDX_W-1:0] wr_next
);

   // Elaboration-time parameter checks
   generate
      if (IDX_W < 2 || IDX_W > 10) begin : g_bad_idx_w
         $error("frame_walker: IDX_W must lie in 2..10");
      end
      if (VPN_W < 1 || PID_W < 1) begin : g_bad_tag_w
         $error("frame_walker: tag widths must be at least 1");
      end
   endgenerate

   logic [IDX_W-1:0] hash_idx;
   logic [IDX_W-1:0] probe_idx;
   logic             rd_valid;
   logic             rd_dirty;
   logic [VPN_W-1:0] rd_vpn;
   logic [PID_W-1:0] rd_pid;
   logic [IDX_W-1:0] rd_next;

   fwalk_hash #(
      .VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W), .HASH_PID(HASH_PID)
   ) u_hash (
      .vpn (req_vpn),
      .pid (req_pid),
      .idx (hash_idx)
   );

   fwalk_table #(
      .VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_valid (wr_valid),
      .wr_dirty (wr_dirty),
      .wr_vpn   (wr_vpn),
      .wr_pid   (wr_pid),
      .wr_next  (wr_next),
      .rd_idx   (probe_idx),
      .rd_valid (rd_valid),
      .rd_dirty (rd_dirty),
      .rd_vpn   (rd_vpn),
      .rd_pid   (rd_pid),
      .rd_next  (rd_next)
   );

   fwalk_ctrl #(
      .VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_vpn   (req_vpn),
      .req_pid   (req_pid),
      .hash_idx  (hash_idx),
      .req_ready (req_ready),
      .probe_idx (probe_idx),
      .rd_valid  (rd_valid),
      .rd_dirty  (rd_dirty),
      .rd_vpn    (rd_vpn),
      .rd_pid    (rd_pid),
      .rd_next   (rd_next),
      .rsp_valid (rsp_valid),
      .rsp_fault (rsp_fault),
      .rsp_frame (rsp_frame),
      .rsp_dirty (rsp_dirty)
   );

endmodule

// File: rtl/fwalk_chk.sv
module fwalk_chk #(
   parameter int unsigned IDX_W = 4
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic rsp_valid
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [IDX_W+1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy_cnt <= '0;
      else if (req_ready) busy_cnt <= '0;
      else                busy_cnt <= busy_cnt + 1'b1;
   end

   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (req_ready && !rsp_valid));

   a_r8_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r8_rsp_frees: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);

   a_r4_rsp_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!req_ready));

   a_r7_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= (IDX_W+2)'(DEPTH));

endmodule

bind frame_walker fwalk_chk #(.IDX_W(IDX_W)) u_fwalk_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid)
);

// File: tb/tb_frame_walker.sv
module tb_frame_walker;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned VPN_W = 20;
   localparam int unsigned PID_W = 8;
   localparam int unsigned IDX_W = 4;
   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam logic [IDX_W-1:0] NUL = '1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [VPN_W-1:0] req_vpn = '0;
   logic [PID_W-1:0] req_pid = '0;
   logic             rsp_valid, rsp_fault, rsp_dirty;
   logic [IDX_W-1:0] rsp_frame;
   logic             wr_en = 1'b0, wr_valid = 1'b0, wr_dirty = 1'b0;
   logic [IDX_W-1:0] wr_idx = '0, wr_next = '0;
   logic [VPN_W-1:0] wr_vpn = '0;
   logic [PID_W-1:0] wr_pid = '0;

   frame_walker #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W), .HASH_PID(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vpn(req_vpn), .req_pid(req_pid), .rsp_valid(rsp_valid),
      .rsp_fault(rsp_fault), .rsp_frame(rsp_frame), .rsp_dirty(rsp_dirty),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
      .wr_vpn(wr_vpn), .wr_pid(wr_pid), .wr_next(wr_next));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string rq, input string what,
                        input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // Software view of the table
   logic             m_valid [DEPTH];
   logic             m_dirty [DEPTH];
   logic [VPN_W-1:0] m_vpn   [DEPTH];
   logic [PID_W-1:0] m_pid   [DEPTH];
   logic [IDX_W-1:0] m_next  [DEPTH];

   typedef struct {
      logic             fault;
      logic [IDX_W-1:0] frame;
      logic             dirty;
      int               due;
      string            rq;
   } exp_t;

   exp_t sb [$];

   function automatic logic [IDX_W-1:0] hash_ref(input logic [VPN_W-1:0] v,
                                                  input logic [PID_W-1:0] p);
      logic [IDX_W-1:0] h = '0;
      for (int i = 0; i < 5; i++) h ^= v[i*4 +: 4];
      for (int i = 0; i < 2; i++) h ^= p[i*4 +: 4];
      return h;
   endfunction

   task automatic wr(input logic [IDX_W-1:0] idx, input logic v, input logic d,
                     input logic [VPN_W-1:0] vp, input logic [PID_W-1:0] pd,
                     input logic [IDX_W-1:0] nx);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_valid = v; wr_dirty = d;
      wr_vpn = vp; wr_pid = pd; wr_next = nx;
      @(negedge clk);
      wr_en = 1'b0;
      m_valid[idx] = v; m_dirty[idx] = d; m_vpn[idx] = vp;
      m_pid[idx] = pd; m_next[idx] = nx;
   endtask

   task automatic lookup(input logic [VPN_W-1:0] vp, input logic [PID_W-1:0] pd,
                         input string rq);
      exp_t e;
      logic [IDX_W-1:0] idx;
      int n;
      bit found;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      idx = hash_ref(vp, pd);
      found = 1'b0;
      n = 0;
      e.fault = 1'b1; e.frame = '0; e.dirty = 1'b0; e.rq = rq;
      for (int s = 0; s < int'(DEPTH); s++) begin
         n = s + 1;
         if (m_valid[idx] && m_vpn[idx] == vp && m_pid[idx] == pd) begin
            e.fault = 1'b0; e.frame = idx; e.dirty = m_dirty[idx]; found = 1'b1;
            break;
         end
         if (m_next[idx] == NUL) break;
         idx = m_next[idx];
      end
      req_valid = 1'b1; req_vpn = vp; req_pid = pd;
      @(negedge clk);
      req_valid = 1'b0;
      e.due = cyc + n;
      sb.push_back(e);
      check(req_ready == 1'b0, "R8", "ready low after accept", int'(req_ready), 0);
   endtask

   task automatic drain();
      @(negedge clk);
      while (sb.size() != 0 || !req_ready) @(negedge clk);
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R8", "unexpected response", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(rsp_fault == e.fault, e.rq, "fault flag", int'(rsp_fault), int'(e.fault));
            check(cyc == e.due, "R4", "response cycle", cyc, e.due);
            if (!e.fault) begin
               check(rsp_frame == e.frame, e.rq, "frame", int'(rsp_frame), int'(e.frame));
               check(rsp_dirty == e.dirty, e.rq, "dirty", int'(rsp_dirty), int'(e.dirty));
            end
            check(req_ready == 1'b1, "R8", "ready with response", int'(req_ready), 1);
         end
      end
   end

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < int'(DEPTH); i++) begin
         m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_vpn[i] = '0; m_pid[i] = '0; m_next[i] = NUL;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      check(rsp_valid == 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);

      // R1: empty table faults on first probe
      lookup(20'h00003, 8'h00, "R1");
      drain();

      // R9/R3: single entry hit at head
      wr(4'd3, 1'b1, 1'b0, 20'h00003, 8'h00, NUL);
      lookup(20'h00003, 8'h00, "R3");
      // R3: same vpn, other pid (hash 3) must not hit
      lookup(20'h00003, 8'h11, "R3");
      drain();

      // R4: chain 4 -> 7 -> 9, hit on third probe, dirty returned
      wr(4'd4, 1'b1, 1'b0, 20'h00040, 8'h00, 4'd7);
      wr(4'd7, 1'b1, 1'b0, 20'h00099, 8'h00, 4'd9);
      wr(4'd9, 1'b1, 1'b1, 20'h00004, 8'h00, NUL);
      lookup(20'h00004, 8'h00, "R4");
      lookup(20'h00040, 8'h00, "R4");
      // R6: key hashing to 4 with no entry walks to null
      lookup(20'h00334, 8'h00, "R6");
      drain();

      // R5: invalid entry with matching tag is skipped
      wr(4'd5, 1'b0, 1'b0, 20'h00005, 8'h00, 4'd6);
      wr(4'd6, 1'b1, 1'b0, 20'h00005, 8'h00, NUL);
      lookup(20'h00005, 8'h00, "R5");
      drain();

      // R2: pid is part of the hash
      wr(4'd0, 1'b1, 1'b0, 20'h12345, 8'h01, NUL);
      wr(4'd2, 1'b1, 1'b1, 20'h12345, 8'h30, NUL);
      lookup(20'h12345, 8'h01, "R2");
      lookup(20'h12345, 8'h30, "R2");
      drain();

      // R7: circular chain 10 -> 11 -> 12 -> 10, fault after DEPTH probes
      wr(4'd10, 1'b1, 1'b0, 20'hAAAAA, 8'h55, 4'd11);
      wr(4'd11, 1'b1, 1'b0, 20'hAAAAA, 8'h55, 4'd12);
      wr(4'd12, 1'b1, 1'b0, 20'hAAAAA, 8'h55, 4'd10);
      lookup(20'h0000A, 8'h00, "R7");
      // R8: requests offered while busy are ignored
      for (int k = 0; k < 5; k++) begin
         req_valid = 1'b1; req_vpn = 20'h00003; req_pid = 8'h00;
         @(negedge clk);
         check(req_ready == 1'b0, "R8", "ready low while walking", int'(req_ready), 0);
      end
      req_valid = 1'b0;
      drain();
      repeat (4) @(negedge clk);

      // R9: clearing the valid bit removes the mapping
      wr(4'd3, 1'b0, 1'b0, 20'h00003, 8'h00, NUL);
      lookup(20'h00003, 8'h00, "R9");
      drain();

      check(sb.size() == 0, "R8", "scoreboard empty", sb.size(), 0);
      done = 1'b1;
      finish_run();
   end

endmodule